// File: doc/BRIEF.md
# Redundancy and Reduction Datapath for Accelerator Slots

This block sits between a shared data bus and a row of identical accelerator slots. On the way out it steers each incoming word to the slots. In parallel and reduction styles a word goes to one addressed slot, so every slot receives its own block. In the redundant styles (dual compare and triple vote) the same word goes to every enabled slot at once.

On the way back the block merges what the slots return, in one of four runtime modes. Parallel mode is a plain bypass: the word from one selected slot is registered and passed on unchecked. Dual mode compares the enabled slots' words and flags any difference. Triple mode forms a bitwise majority and marks each slot that disagrees with it. Reduction mode folds the enabled slots' words with ADD, MAX or MIN. The folded value is kept in a result register, which is read back through a small control interface.

The control interface addresses slots by a kernel ID. A write pulses a reset to every slot that carries that ID. A read returns the stored reduction result and, when the ID matches any slot, loads the reduction operation code. A sticky error bit gathers compare and vote failures until software clears it.

Top module: `redred_datapath`

## Requirements
- R1: In parallel mode (`cfg_mode`=0) and reduction mode (`cfg_mode`=3), a valid input word raises `slot_wr_valid` in the same cycle only for the slot numbered `in_slot`, and only if that slot is enabled in `slot_en`. All slots see the word on `slot_wr_data`.
- R2: In dual mode (`cfg_mode`=1) and triple mode (`cfg_mode`=2), a valid input word raises `slot_wr_valid` for exactly the enabled slots.
- R3: In parallel mode, a valid word from slot `rd_sel` appears on `out_data` with `out_valid` one cycle later. `out_mismatch` and `out_disagree` stay low.
- R4: In dual mode, the output word is the word of the lowest-numbered enabled slot. `out_mismatch` is high when any enabled slot's word differs from it.
- R5: In triple mode, each output bit is 1 when more than half of the enabled slots hold a 1 in that bit. `out_disagree[i]` is set for each enabled slot whose word differs from that majority, and `out_mismatch` is high when any flag is set.
- R6: In reduction mode, the enabled slots' words are folded with the stored operation code: 0 or 3 selects ADD, which wraps modulo 2^DW; 1 selects signed MAX; 2 selects signed MIN. The result appears on `out_data` and is kept in the result register.
- R7: Words returned by slots that are disabled in `slot_en` are ignored by the bypass, the comparator, the voter and the reduction.
- R8: In dual, triple and reduction modes, words may arrive over several cycles. `out_valid` rises exactly one cycle after the last enabled slot's word is accepted, and stays low before that.
- R9: `err_sticky` is set one cycle after a dual or triple result with a mismatch. It stays set until a cycle with `ctl_clr_err` high, and a new error in that same cycle wins over the clear.
- R10: A control write (`ctl_valid`=1, `ctl_write`=1) pulses `slot_rst` for one cycle, on the next cycle, for every slot whose kernel ID in `slot_kid` equals `ctl_kid`.
- R11: A control read (`ctl_valid`=1, `ctl_write`=0) returns the result register on `ctl_rdata` with `ctl_rvalid` one cycle later. It loads `ctl_op` as the reduction code only if some slot's kernel ID matches `ctl_kid`.
- R12: After reset, `out_valid`, `err_sticky`, `ctl_rvalid` and `slot_rst` are low, the result register is 0 and the operation code is ADD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 parallel, 1 dual, 2 triple, 3 reduction |
| slot_en | input | NSLOT | Active-slot mask |
| in_valid | input | 1 | Outgoing word valid |
| in_data | input | DW | Outgoing word |
| in_slot | input | SW | Target slot for parallel and reduction sends |
| slot_wr_valid | output | NSLOT | Per-slot write strobe |
| slot_wr_data | output | DW | Word delivered to the slots |
| slot_rd_valid | input | NSLOT | Per-slot return valid |
| slot_rd_data | input | NSLOT*DW | Returned words, slot i in bits [i*DW +: DW] |
| rd_sel | input | SW | Bypass source slot in parallel mode |
| out_valid | output | 1 | Merged word valid |
| out_data | output | DW | Merged word |
| out_mismatch | output | 1 | Compare or vote failure for this word |
| out_disagree | output | NSLOT | Slots that differ from the majority |
| err_sticky | output | 1 | Accumulated error |
| ctl_valid | input | 1 | Control access strobe |
| ctl_write | input | 1 | 1 write (slot reset), 0 read |
| ctl_kid | input | KW | Kernel ID addressed |
| ctl_op | input | 2 | Reduction code supplied with a read |
| ctl_clr_err | input | 1 | Clears the sticky error |
| slot_kid | input | NSLOT*KW | Kernel ID of each slot |
| slot_rst | output | NSLOT | One-cycle slot reset pulses |
| ctl_rvalid | output | 1 | Read data valid |
| ctl_rdata | output | DW | Reduction result read back |

## Verification
The assertions check, on every cycle, several shape rules. A parallel or reduction send never strobes more than one slot. No strobe ever goes to a disabled slot. A disagreement flag never appears without a valid, failing output. The sticky error holds until cleared, and control accesses produce their reset pulses and read responses only when asked. The values themselves can only be shown by the bench's scenarios: the majority bits, the lowest-slot compare word, wrapping sums and signed extremes. The same holds for the exact cycle of completion when words are split across cycles, for garbage on disabled slots being ignored, and for an operation code kept across a read that matched no kernel ID.

// File: rtl/redred_pkg.sv
package redred_pkg;
  typedef enum logic [1:0] {
    MD_PAR = 2'd0,
    MD_DMR = 2'd1,
    MD_TMR = 2'd2,
    MD_RED = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_MAX  = 2'd1,
    OP_MIN  = 2'd2,
    OP_ADDX = 2'd3
  } op_e;
endpackage

// File: rtl/redred_scatter.sv
module redred_scatter
  import redred_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic [NSLOT-1:0] slot_en,
  input  logic             in_valid,
  input  logic [SW-1:0]    in_slot,
  output logic [NSLOT-1:0] wr_valid
);
  logic bcast;
  logic [NSLOT-1:0] target;

  assign bcast = (mode == MD_DMR) || (mode == MD_TMR);

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_tgt
      assign target[i] = (in_slot == SW'(i)) && slot_en[i];
    end
  endgenerate

  always_comb begin
    wr_valid = '0;
    if (in_valid) wr_valid = bcast ? slot_en : target;
  end

  // R1: a split send strobes at most one slot
  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bcast) |-> $onehot0(wr_valid));
  // R2, R7: strobes never reach a disabled slot
  assert_no_disabled_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid & ~slot_en) == '0);
endmodule

// File: rtl/redred_gather.sv
module redred_gather
  import redred_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int DW    = 16,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  mode_e                     mode,
  input  op_e                       op,
  input  logic [NSLOT-1:0]          slot_en,
  input  logic [SW-1:0]             rd_sel,
  input  logic [NSLOT-1:0]          rd_valid,
  input  logic [NSLOT-1:0][DW-1:0]  rd_data,
  output logic                      out_valid,
  output logic [DW-1:0]             out_data,
  output logic                      out_mismatch,
  output logic [NSLOT-1:0]          out_disagree,
  output logic                      err_evt,
  output logic                      red_done,
  output logic [DW-1:0]             red_value
);
  // Bitwise majority over the masked words
  function automatic logic [DW-1:0] f_major(input logic [NSLOT-1:0][DW-1:0] w,
                                           input logic [NSLOT-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < DW; b++) begin
      int ones;
      int tot;
      ones = 0;
      tot  = 0;
      for (int i = 0; i < NSLOT; i++) begin
        if (m[i]) begin
          tot  = tot + 1;
          ones = ones + int'(w[i][b]);
        end
      end
      r[b] = (2 * ones > tot);
    end
    return r;
  endfunction

  // Word of the lowest masked slot
  function automatic logic [DW-1:0] f_first(input logic [NSLOT-1:0][DW-1:0] w,
                                           input logic [NSLOT-1:0] m);
    logic [DW-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (m[i] && !found) begin
        r = w[i];
        found = 1'b1;
      end
    end
    return r;
  endfunction

  // Fold masked words with the selected operation
  function automatic logic [DW-1:0] f_fold(input logic [NSLOT-1:0][DW-1:0] w,
                                          input logic [NSLOT-1:0] m, input op_e o);
    logic [DW-1:0] a;
    logic started;
    a = '0;
    started = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (m[i]) begin
        if (!started) begin
          a = w[i];
          started = 1'b1;
        end else begin
          case (o)
            OP_MAX:  if ($signed(w[i]) > $signed(a)) a = w[i];
            OP_MIN:  if ($signed(w[i]) < $signed(a)) a = w[i];
            default: a = a + w[i];
          endcase
        end
      end
    end
    return a;
  endfunction

  logic                     combine;
  logic [NSLOT-1:0]         acc;
  logic [NSLOT-1:0]         got_q;
  logic [NSLOT-1:0][DW-1:0] held_q;
  logic [NSLOT-1:0][DW-1:0] merged;
  logic                     complete;
  logic [DW-1:0]            maj_w;
  logic [DW-1:0]            first_w;
  logic [NSLOT-1:0]         dis_w;
  logic                     dmr_diff;
  logic                     bypass_hit;

  assign combine    = (mode != MD_PAR);
  assign acc        = combine ? (rd_valid & slot_en) : '0;
  assign complete   = combine && (slot_en != '0) && (((got_q | acc) & slot_en) == slot_en);
  assign bypass_hit = !combine && rd_valid[rd_sel] && slot_en[rd_sel];

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_merge
      assign merged[i] = acc[i] ? rd_data[i] : held_q[i];
      assign dis_w[i]  = (mode == MD_TMR) && slot_en[i] && (merged[i] != maj_w);
    end
  endgenerate

  always_comb begin
    maj_w    = f_major(merged, slot_en);
    first_w  = f_first(merged, slot_en);
    dmr_diff = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_en[i] && merged[i] != first_w) dmr_diff = 1'b1;
    end
  end

  assign red_value = f_fold(merged, slot_en, op);
  assign red_done  = complete && (mode == MD_RED);
  assign err_evt   = complete && (((mode == MD_DMR) && dmr_diff) ||
                                  ((mode == MD_TMR) && (dis_w != '0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got_q        <= '0;
      held_q       <= '0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_mismatch <= 1'b0;
      out_disagree <= '0;
    end else begin
      out_valid    <= 1'b0;
      out_mismatch <= 1'b0;
      out_disagree <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        if (acc[i]) held_q[i] <= rd_data[i];
      end
      if (!combine) begin
        got_q <= '0;
        if (bypass_hit) begin
          out_valid <= 1'b1;
          out_data  <= rd_data[rd_sel];
        end
      end else if (complete) begin
        got_q        <= '0;
        out_valid    <= 1'b1;
        out_mismatch <= err_evt;
        out_disagree <= dis_w;
        case (mode)
          MD_DMR:  out_data <= first_w;
          MD_TMR:  out_data <= maj_w;
          default: out_data <= red_value;
        endcase
      end else begin
        got_q <= got_q | acc;
      end
    end
  end

  // R3: the bypass never reports an error
  assert_bypass_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PAR) |=> !out_mismatch && (out_disagree == '0));
  // R5: disagreement flags only travel with a failing valid word
  assert_disagree_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_disagree != '0) |-> (out_valid && out_mismatch));
  // R8: an unfinished collection yields no output
  assert_no_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (combine && !complete) |=> !out_valid);
endmodule

// File: rtl/redred_ctl.sv
module redred_ctl
  import redred_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int DW    = 16,
  parameter int KW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_valid,
  input  logic                     ctl_write,
  input  logic [KW-1:0]            ctl_kid,
  input  op_e                      ctl_op,
  input  logic                     ctl_clr_err,
  input  logic [NSLOT-1:0][KW-1:0] slot_kid,
  input  logic                     err_evt,
  input  logic                     red_done,
  input  logic [DW-1:0]            red_value,
  output logic [NSLOT-1:0]         slot_rst,
  output op_e                      red_op,
  output logic                     err_sticky,
  output logic                     ctl_rvalid,
  output logic [DW-1:0]            ctl_rdata
);
  logic [NSLOT-1:0] hit;
  logic [DW-1:0]    result_q;
  logic             wr_req;
  logic             rd_req;

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_hit
      assign hit[i] = (slot_kid[i] == ctl_kid);
    end
  endgenerate

  assign wr_req = ctl_valid && ctl_write;
  assign rd_req = ctl_valid && !ctl_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_rst   <= '0;
      red_op     <= OP_ADD;
      err_sticky <= 1'b0;
      ctl_rvalid <= 1'b0;
      ctl_rdata  <= '0;
      result_q   <= '0;
    end else begin
      slot_rst   <= wr_req ? hit : '0;
      ctl_rvalid <= rd_req;
      if (rd_req) begin
        ctl_rdata <= result_q;
        if (hit != '0) red_op <= ctl_op;
      end
      if (red_done) result_q <= red_value;
      err_sticky <= err_evt || (err_sticky && !ctl_clr_err);
    end
  end

  // R9: a failure always reaches the sticky bit
  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_sticky);
  // R9: only a clear drops the sticky bit
  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !ctl_clr_err) |=> err_sticky);
  // R10: no reset pulse without a control write
  assert_rst_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> (slot_rst == '0));
  // R11: every read gets a response on the next cycle
  assert_read_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> ctl_rvalid);
endmodule

// File: rtl/redred_datapath.sv
module redred_datapath
  import redred_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int DW    = 16,
  parameter int KW    = 4,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_mode,
  input  logic [NSLOT-1:0]      slot_en,
  input  logic                  in_valid,
  input  logic [DW-1:0]         in_data,
  input  logic [SW-1:0]         in_slot,
  output logic [NSLOT-1:0]      slot_wr_valid,
  output logic [DW-1:0]         slot_wr_data,
  input  logic [NSLOT-1:0]      slot_rd_valid,
  input  logic [NSLOT*DW-1:0]   slot_rd_data,
  input  logic [SW-1:0]         rd_sel,
  output logic                  out_valid,
  output logic [DW-1:0]         out_data,
  output logic                  out_mismatch,
  output logic [NSLOT-1:0]      out_disagree,
  output logic                  err_sticky,
  input  logic                  ctl_valid,
  input  logic                  ctl_write,
  input  logic [KW-1:0]         ctl_kid,
  input  logic [1:0]            ctl_op,
  input  logic                  ctl_clr_err,
  input  logic [NSLOT*KW-1:0]   slot_kid,
  output logic [NSLOT-1:0]      slot_rst,
  output logic                  ctl_rvalid,
  output logic [DW-1:0]         ctl_rdata
);
  mode_e                     mode;
  op_e                       cur_op;
  logic [NSLOT-1:0][DW-1:0]  rd_words;
  logic [NSLOT-1:0][KW-1:0]  kids;
  logic                      err_evt;
  logic                      red_done;
  logic [DW-1:0]             red_value;

  assign mode         = mode_e'(cfg_mode);
  assign rd_words     = slot_rd_data;
  assign kids         = slot_kid;
  assign slot_wr_data = in_data;

  redred_scatter #(.NSLOT(NSLOT), .SW(SW)) scatter_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .slot_en(slot_en),
    .in_valid(in_valid), .in_slot(in_slot), .wr_valid(slot_wr_valid)
  );

  redred_gather #(.NSLOT(NSLOT), .DW(DW), .SW(SW)) gather_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .op(cur_op), .slot_en(slot_en),
    .rd_sel(rd_sel), .rd_valid(slot_rd_valid), .rd_data(rd_words),
    .out_valid(out_valid), .out_data(out_data), .out_mismatch(out_mismatch),
    .out_disagree(out_disagree), .err_evt(err_evt), .red_done(red_done),
    .red_value(red_value)
  );

  redred_ctl #(.NSLOT(NSLOT), .DW(DW), .KW(KW)) ctl_i (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_write(ctl_write),
    .ctl_kid(ctl_kid), .ctl_op(op_e'(ctl_op)), .ctl_clr_err(ctl_clr_err),
    .slot_kid(kids), .err_evt(err_evt), .red_done(red_done),
    .red_value(red_value), .slot_rst(slot_rst), .red_op(cur_op),
    .err_sticky(err_sticky), .ctl_rvalid(ctl_rvalid), .ctl_rdata(ctl_rdata)
  );
endmodule

// File: tb/redred_datapath_tb.sv
module redred_datapath_tb_top;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int KW = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_mode;
  logic [N-1:0] slot_en;
  logic in_valid;
  logic [W-1:0] in_data;
  logic [1:0] in_slot;
  logic [N-1:0] slot_wr_valid;
  logic [W-1:0] slot_wr_data;
  logic [N-1:0] slot_rd_valid;
  logic [N-1:0][W-1:0] rdw;
  logic [1:0] rd_sel;
  logic out_valid;
  logic [W-1:0] out_data;
  logic out_mismatch;
  logic [N-1:0] out_disagree;
  logic err_sticky;
  logic ctl_valid, ctl_write, ctl_clr_err;
  logic [KW-1:0] ctl_kid;
  logic [1:0] ctl_op;
  logic [N-1:0][KW-1:0] kids;
  logic [N-1:0] slot_rst;
  logic ctl_rvalid;
  logic [W-1:0] ctl_rdata;

  int n_chk = 0;
  int n_err = 0;
  logic exp_err = 1'b0;
  logic [W-1:0] exp_res = '0;
  logic [1:0] cur_op = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  redred_datapath #(.NSLOT(N), .DW(W), .KW(KW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .slot_en(slot_en),
    .in_valid(in_valid), .in_data(in_data), .in_slot(in_slot),
    .slot_wr_valid(slot_wr_valid), .slot_wr_data(slot_wr_data),
    .slot_rd_valid(slot_rd_valid), .slot_rd_data(rdw), .rd_sel(rd_sel),
    .out_valid(out_valid), .out_data(out_data), .out_mismatch(out_mismatch),
    .out_disagree(out_disagree), .err_sticky(err_sticky),
    .ctl_valid(ctl_valid), .ctl_write(ctl_write), .ctl_kid(ctl_kid),
    .ctl_op(ctl_op), .ctl_clr_err(ctl_clr_err), .slot_kid(kids),
    .slot_rst(slot_rst), .ctl_rvalid(ctl_rvalid), .ctl_rdata(ctl_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Reference models, written from the requirements
  function automatic logic [W-1:0] m_vote(input logic [N-1:0][W-1:0] w, input logic [N-1:0] m);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) begin
      int one_n;
      int zero_n;
      one_n = 0;
      zero_n = 0;
      for (int i = 0; i < N; i++)
        if (m[i]) begin
          if (w[i][b]) one_n++; else zero_n++;
        end
      r[b] = one_n > zero_n;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] m_low(input logic [N-1:0][W-1:0] w, input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return w[i];
    return '0;
  endfunction

  function automatic logic [W-1:0] m_fold(input logic [N-1:0][W-1:0] w, input logic [N-1:0] m,
                                         input logic [1:0] o);
    int sum;
    int best;
    logic have;
    sum = 0;
    best = 0;
    have = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        int v;
        v = int'($signed(w[i]));
        sum = sum + int'(w[i]);
        if (!have) best = v;
        else if (o == 2'd1 && v > best) best = v;
        else if (o == 2'd2 && v < best) best = v;
        have = 1'b1;
      end
    end
    if (o == 2'd1 || o == 2'd2) return best[W-1:0];
    return sum[W-1:0];
  endfunction

  task automatic ctl_read(input logic [KW-1:0] kid, input logic [1:0] op);
    ctl_valid = 1'b1; ctl_write = 1'b0; ctl_kid = kid; ctl_op = op;
    tick();
    ctl_valid = 1'b0;
    chk("R11 rvalid", ctl_rvalid, 1);
    chk("R11 rdata", ctl_rdata, exp_res);
    if (kid == 4'd1 || kid == 4'd2 || kid == 4'd3) cur_op = op;
  endtask

  // Drive one collection in two parts, then check the merged word
  task automatic run_combine(input logic [1:0] md, input logic [N-1:0] en,
                             input logic [N-1:0][W-1:0] w, input logic [N-1:0] part_in);
    logic [N-1:0] part;
    logic [W-1:0] e_data;
    logic e_mis;
    logic [N-1:0] e_dis;
    cfg_mode = md; slot_en = en;
    part = part_in & en;
    if (part == '0 || part == en) part = en;
    e_dis = '0;
    e_mis = 1'b0;
    if (md == 2'd1) begin
      e_data = m_low(w, en);
      for (int i = 0; i < N; i++) if (en[i] && w[i] != e_data) e_mis = 1'b1;
    end else if (md == 2'd2) begin
      e_data = m_vote(w, en);
      for (int i = 0; i < N; i++) e_dis[i] = en[i] && (w[i] != e_data);
      e_mis = (e_dis != '0);
    end else begin
      e_data = m_fold(w, en, cur_op);
    end
    for (int i = 0; i < N; i++) rdw[i] = en[i] ? w[i] : W'($urandom);
    slot_rd_valid = part | (~en & N'($urandom));
    tick();
    if (part != en) begin
      chk("R8 no early valid", out_valid, 0);
      for (int i = 0; i < N; i++) if (!en[i]) rdw[i] = W'($urandom);
      slot_rd_valid = (en & ~part) | (~en & N'($urandom));
      tick();
    end
    slot_rd_valid = '0;
    chk("R8 valid after last word", out_valid, 1);
    if (md == 2'd1) chk("R4 R7 dual word", out_data, e_data);
    else if (md == 2'd2) chk("R5 R7 vote word", out_data, e_data);
    else chk("R6 R7 fold result", out_data, e_data);
    chk("R4 R5 mismatch", out_mismatch, e_mis);
    chk("R5 disagree flags", out_disagree, e_dis);
    if (md == 2'd3) exp_res = e_data;
    exp_err = exp_err | e_mis;
    chk("R9 sticky", err_sticky, exp_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0][W-1:0] w;
    void'($urandom(32'd1234));
    kids = {4'd3, 4'd1, 4'd2, 4'd1};
    rst_n = 1'b0; cfg_mode = 2'd0; slot_en = '0; in_valid = 1'b0; in_data = '0;
    in_slot = '0; slot_rd_valid = '0; rdw = '0; rd_sel = '0; ctl_valid = 1'b0;
    ctl_write = 1'b0; ctl_kid = '0; ctl_op = '0; ctl_clr_err = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R12 out_valid", out_valid, 0);
    chk("R12 err", err_sticky, 0);
    chk("R12 rvalid", ctl_rvalid, 0);
    chk("R12 slot_rst", slot_rst, 0);
    ctl_read(4'd7, 2'd1);  // result 0; unmatched ID keeps ADD

    // R1 / R2 send steering
    for (int k = 0; k < 16; k++) begin
      logic [1:0] md;
      md = 2'($urandom);
      cfg_mode = md; slot_en = 4'($urandom); in_slot = 2'($urandom);
      in_valid = 1'b1; in_data = 16'($urandom);
      #1;
      if (md == 2'd1 || md == 2'd2) chk("R2 broadcast", slot_wr_valid, slot_en);
      else chk("R1 single slot", slot_wr_valid, slot_en & (4'b1 << in_slot));
      chk("R1 data", slot_wr_data, in_data);
      tick();
    end
    in_valid = 1'b0;

    // R3 bypass, R7 disabled source
    cfg_mode = 2'd0; slot_en = 4'b1011;
    for (int k = 0; k < 8; k++) begin
      rd_sel = 2'($urandom);
      for (int i = 0; i < N; i++) rdw[i] = 16'($urandom);
      slot_rd_valid = 4'b1111;
      tick();
      chk("R3 R7 bypass valid", out_valid, slot_en[rd_sel]);
      if (slot_en[rd_sel]) chk("R3 bypass data", out_data, rdw[rd_sel]);
      chk("R3 no error", out_mismatch, 0);
    end
    slot_rd_valid = '0;
    tick();

    // R6 directed corners: wrap, signed extremes
    w = {16'h0, 16'h0, 16'h0002, 16'hFFFF};
    run_combine(2'd3, 4'b0011, w, 4'b0001);
    chk("R6 add wrap", out_data, 16'h0001);
    ctl_read(4'd2, 2'd1);
    w = {16'h0, 16'h7FFF, 16'h0001, 16'h8000};
    run_combine(2'd3, 4'b0111, w, 4'b0000);
    chk("R6 signed max", out_data, 16'h7FFF);
    ctl_read(4'd9, 2'd2);  // R11 miss: MAX stays
    w = {16'h0, 16'h0, 16'h0005, 16'hFFFE};
    run_combine(2'd3, 4'b0011, w, 4'b0010);
    chk("R11 op kept on miss", out_data, 16'h0005);
    ctl_read(4'd3, 2'd2);
    w = {16'h0, 16'h7FFF, 16'h0001, 16'h8000};
    run_combine(2'd3, 4'b0111, w, 4'b0000);
    chk("R6 signed min", out_data, 16'h8000);

    // Random mix of dual, triple and reduction collections
    for (int it = 0; it < 60; it++) begin
      logic [1:0] md;
      logic [N-1:0] en;
      logic [W-1:0] base;
      md = 2'd1 + 2'($urandom % 3);
      en = 4'($urandom);
      if (md == 2'd2 && ($urandom % 2 == 0)) en = 4'b0111;
      if (en == '0) en = 4'b0101;
      base = 16'($urandom);
      for (int i = 0; i < N; i++) begin
        w[i] = (md == 2'd3) ? 16'($urandom) : base;
        if (md != 2'd3 && ($urandom % 3 == 0)) w[i] = w[i] ^ (16'd1 << ($urandom % 16));
      end
      if (md == 2'd3) ctl_read(4'd1, 2'($urandom % 4));
      run_combine(md, en, w, 4'($urandom));
    end

    // R9 clear, then hold low
    w = {16'h1, 16'h1, 16'h2, 16'h1};
    run_combine(2'd1, 4'b0011, w, 4'b0000);
    ctl_clr_err = 1'b1;
    tick();
    ctl_clr_err = 1'b0;
    exp_err = 1'b0;
    chk("R9 cleared", err_sticky, 0);
    tick();
    chk("R9 stays clear", err_sticky, 0);

    // R10 multicast reset
    ctl_valid = 1'b1; ctl_write = 1'b1; ctl_kid = 4'd1;
    tick();
    ctl_valid = 1'b0;
    chk("R10 kid1 pulse", slot_rst, 4'b0101);
    tick();
    chk("R10 pulse ends", slot_rst, 4'b0000);
    ctl_valid = 1'b1; ctl_write = 1'b1; ctl_kid = 4'd3;
    tick();
    chk("R10 kid3 pulse", slot_rst, 4'b1000);
    ctl_kid = 4'd9;
    tick();
    ctl_valid = 1'b0;
    chk("R10 no match", slot_rst, 4'b0000);
    ctl_read(4'd2, 2'd0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule